// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with `NCH` independent down-counting channels (two by default), each `DW` bits wide (32 by default). Each channel has a control register, an interval register and a read-only current-count register. Software writes an interval, then starts the channel in periodic or one-shot mode. The channel decrements once per divided tick. The tick is one of four external tick-enable inputs, selected per channel, and then divided by a power-of-two prescaler. When a channel expires it raises its bit in a shared status register. A shared enable register masks which status bits drive the single interrupt line. Software clears a status bit by writing a one to it.

Each channel is a four-state machine:
- **IDLE**: stopped.
- **RUN**: counting.
- **STOP**: a disable is pending and the channel keeps counting until the selected source has ticked `STOP_TICKS` times.
- **HALT**: a one-shot channel has expired and holds at zero.

The named transitions are:
- **start** (IDLE→RUN): the enable bit is set.
- **drain** (RUN→STOP): the enable bit is cleared.
- **settle** (STOP→IDLE): `STOP_TICKS` source ticks have elapsed, or a one-shot channel expires while in STOP.
- **resume** (STOP→RUN): the enable bit is set again while in STOP.
- **fire** (RUN→HALT): a one-shot channel expires.
- **rearm** (HALT→RUN): a reload is requested with the enable bit set.
- **release** (HALT→IDLE): the enable bit is cleared.

The bus is a simple synchronous port. A write takes effect at the clock edge where it is presented. Read data is registered.

Top module: `tmr_multi`

## Requirements
- R1: The register offsets are:
  - 0x00: interrupt enable (bit n for channel n).
  - 0x04: status.
  - Channel n control at 0x10*(n+1), interval at 0x10*(n+1)+0x04, count at 0x10*(n+1)+0x08.
  - All registers reset to zero. Any other offset reads zero. Read data appears on `bus_rdata` one clock after the read request.
- R2: The control register is eight bits wide:
  - Bit 0: enable.
  - Bit 1: reload.
  - Bits 3:2: source select.
  - Bits 6:4: prescaler.
  - Bit 7: one-shot when 1, periodic when 0.
  - Written bits above bit 7 are dropped and read back as zero.
- R3: Setting reload copies the interval into the count. In IDLE or HALT the copy happens one clock after the write. In RUN or STOP it happens at the next divided tick, in place of a decrement. The reload bit reads 1 while the copy is pending and clears itself once the copy is done.
- R4: In RUN or STOP each divided tick lowers the count by one. A divided tick that finds the count at zero is an expiry. In IDLE the count does not change.
- R5: In periodic mode an expiry sets the channel's status bit and reloads the interval. An interval of N therefore gives a period of N+1 divided ticks.
- R6: In one-shot mode an expiry sets the status bit and takes RUN→HALT. The count then holds at zero with no further expiries. Reload with enable set restarts the channel (HALT→RUN). Clearing enable takes HALT→IDLE.
- R7: Prescaler value p yields one divided tick per 2^p selected source ticks. The first divided tick comes on the 2^p-th source tick after leaving IDLE. With an interval of 1 in one-shot mode, the channel expires on source tick 2^(p+1).
- R8: Source select s makes the channel count on `src_tick[s]` only. Ticks on the other inputs leave its count unchanged.
- R9: Clearing enable while in RUN moves the channel to STOP, where counting continues. The channel goes to IDLE after `STOP_TICKS` (default 2) ticks of its selected source. Setting enable again while in STOP returns it to RUN, and counting continues without a gap.
- R10: Writing 1 to status bit n clears it, and writing 0 leaves it alone. A status bit sets on expiry whether or not its enable bit is set.
- R11: `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R12: An interval of all ones is legal: it loads in full and counts down from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Tick enables of the four clock sources |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Timing of each result after its stimulus:
- A register write is visible at the edge where it is presented.
- A reload from IDLE or HALT lands one edge later.
- A count change caused by a tick lands at the edge where the tick is high.
- Read data is captured at the edge of the read request.

The bench gives each write a spare cycle and raises each tick for a single edge. It then issues reads, so every sampled value already includes every earlier update. Interrupt and status checks are sampled at a falling edge after that spare cycle. The prescaler sweep counts source ticks, one at a time, until the status bit appears.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_STOP = 2'd2,
        CH_HALT = 2'd3
    } ch_state_t;

    // control register field positions
    localparam int CTL_W       = 8;
    localparam int CTL_EN      = 0;
    localparam int CTL_RLD     = 1;
    localparam int CTL_SRC_LSB = 2;
    localparam int SRC_W       = 2;
    localparam int CTL_PRE_LSB = 4;
    localparam int PRE_W       = 3;
    localparam int CTL_ONESHOT = 7;
    localparam int NSRC        = 1 << SRC_W;

    // address layout
    localparam int OFS_IEN   = 'h00;
    localparam int OFS_STS   = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h10;
    localparam int SUB_CTL   = 'h0;
    localparam int SUB_INTV  = 'h4;
    localparam int SUB_CNT   = 'h8;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [PRE_W-1:0] pre_sel,
    output logic             tick_out
);
    localparam int ACC_W = (1 << PRE_W) - 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] mask;

    // low pre_sel bits set
    assign mask     = ~({ACC_W{1'b1}} << pre_sel);
    assign tick_out = tick_in && ((acc_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (clr)     acc_q <= '0;
        else if (tick_in) acc_q <= acc_q + 1'b1;
    end
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int DW         = 32,
    parameter int STOP_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             cfg_en,
    input  logic             cfg_rld,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic             cfg_oneshot,
    input  logic [DW-1:0]    interval,
    output logic [DW-1:0]    count,
    output logic             expire,
    output logic             rld_done,
    output logic [1:0]       state
);
    localparam int STP_W = $clog2(STOP_TICKS + 1);

    ch_state_t        st_q, st_n;
    logic [DW-1:0]    cnt_q, cnt_n;
    logic [STP_W-1:0] stp_q, stp_n;
    logic             sel_tick, div_tick, pre_clr;

    assign sel_tick = src_tick[cfg_src];
    assign pre_clr  = (st_q == CH_IDLE) || (st_q == CH_HALT);

    tmr_prescale #(.PRE_W(PRE_W)) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pre_clr),
        .tick_in  (sel_tick),
        .pre_sel  (cfg_pre),
        .tick_out (div_tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
            stp_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            stp_q <= stp_n;
        end
    end

    // next state, count and event strobes
    always_comb begin
        st_n     = st_q;
        cnt_n    = cnt_q;
        stp_n    = stp_q;
        expire   = 1'b0;
        rld_done = 1'b0;
        unique case (st_q)
            CH_IDLE: begin
                stp_n = '0;
                if (cfg_rld) begin
                    cnt_n    = interval;
                    rld_done = 1'b1;
                end
                if (cfg_en) st_n = CH_RUN;              // start
            end
            CH_HALT: begin
                if (cfg_rld) begin
                    cnt_n    = interval;
                    rld_done = 1'b1;
                end
                if (!cfg_en)      st_n = CH_IDLE;       // release
                else if (cfg_rld) st_n = CH_RUN;        // rearm
            end
            CH_RUN, CH_STOP: begin
                if (div_tick) begin
                    if (cfg_rld) begin
                        cnt_n    = interval;
                        rld_done = 1'b1;
                    end else if (cnt_q == '0) begin
                        expire = 1'b1;
                        if (cfg_oneshot)
                            st_n = (st_q == CH_RUN) ? CH_HALT : CH_IDLE; // fire / settle
                        else
                            cnt_n = interval;
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
                if (st_q == CH_RUN) begin
                    if (!cfg_en && st_n == CH_RUN) begin
                        st_n  = CH_STOP;                // drain
                        stp_n = '0;
                    end
                end else if (st_n == CH_STOP) begin
                    if (cfg_en) begin
                        st_n = CH_RUN;                  // resume
                    end else if (sel_tick) begin
                        if (stp_q == STP_W'(STOP_TICKS - 1)) st_n = CH_IDLE; // settle
                        else stp_n = stp_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // outputs
    assign count = cnt_q;
    assign state = st_q;
endmodule

// File: rtl/tmr_multi.sv
`timescale 1ns/1ps
module tmr_multi
    import tmr_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int DW         = 32,
    parameter int ADDR_W     = 8,
    parameter int STOP_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    logic [NCH-1:0]            ien_q, sts_q, sts_clr;
    logic [NCH-1:0][CTL_W-1:0] ctrl_q;
    logic [NCH-1:0][DW-1:0]    intv_q;
    logic [NCH-1:0][DW-1:0]    cnt_w;
    logic [NCH-1:0][1:0]       st_w;
    logic [NCH-1:0]            exp_w, rld_done_w, rld_w;
    logic [DW-1:0]             rd_val;
    logic                      wr_en;

    function automatic logic [ADDR_W-1:0] ch_addr(input int n, input int sub);
        return ADDR_W'(CH_BASE + n * CH_STRIDE + sub);
    endfunction

    assign wr_en   = bus_sel && bus_wr;
    assign sts_clr = (wr_en && bus_addr == ADDR_W'(OFS_STS)) ? bus_wdata[NCH-1:0] : '0;
    assign irq     = |(sts_q & ien_q);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        tmr_chan #(.DW(DW), .STOP_TICKS(STOP_TICKS)) chan_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_tick    (src_tick),
            .cfg_en      (ctrl_q[n][CTL_EN]),
            .cfg_rld     (ctrl_q[n][CTL_RLD]),
            .cfg_src     (ctrl_q[n][CTL_SRC_LSB +: SRC_W]),
            .cfg_pre     (ctrl_q[n][CTL_PRE_LSB +: PRE_W]),
            .cfg_oneshot (ctrl_q[n][CTL_ONESHOT]),
            .interval    (intv_q[n]),
            .count       (cnt_w[n]),
            .expire      (exp_w[n]),
            .rld_done    (rld_done_w[n]),
            .state       (st_w[n])
        );
        assign rld_w[n] = ctrl_q[n][CTL_RLD];
    end

    // read decode
    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_W'(OFS_IEN)) rd_val = DW'(ien_q);
        if (bus_addr == ADDR_W'(OFS_STS)) rd_val = DW'(sts_q);
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == ch_addr(n, SUB_CTL))  rd_val = DW'(ctrl_q[n]);
            if (bus_addr == ch_addr(n, SUB_INTV)) rd_val = intv_q[n];
            if (bus_addr == ch_addr(n, SUB_CNT))  rd_val = cnt_w[n];
        end
    end

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q     <= '0;
            sts_q     <= '0;
            ctrl_q    <= '0;
            intv_q    <= '0;
            bus_rdata <= '0;
        end else begin
            sts_q <= (sts_q & ~sts_clr) | exp_w;
            if (bus_sel && !bus_wr) bus_rdata <= rd_val;
            for (int n = 0; n < NCH; n++)
                if (rld_done_w[n]) ctrl_q[n][CTL_RLD] <= 1'b0;
            if (wr_en) begin
                if (bus_addr == ADDR_W'(OFS_IEN)) ien_q <= bus_wdata[NCH-1:0];
                for (int n = 0; n < NCH; n++) begin
                    if (bus_addr == ch_addr(n, SUB_CTL))  ctrl_q[n] <= bus_wdata[CTL_W-1:0];
                    if (bus_addr == ch_addr(n, SUB_INTV)) intv_q[n] <= bus_wdata;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_multi_chk.sv
`timescale 1ns/1ps
module tmr_multi_chk
    import tmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   irq,
    input logic [NCH-1:0]         ien_q,
    input logic [NCH-1:0]         sts_q,
    input logic [NCH-1:0]         exp_w,
    input logic [NCH-1:0]         rld_w,
    input logic [NCH-1:0][1:0]    st_w,
    input logic [NCH-1:0][DW-1:0] cnt_w
);
    // R11: interrupt only with a pending bit and an enabled bit
    a_r11_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts_q != '0));
    a_r11_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q != '0));

    for (genvar n = 0; n < NCH; n++) begin : g_a
        // R6: a halted channel holds zero
        a_r6_halt_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w[n] == 2'(CH_HALT)) |-> (cnt_w[n] == '0));
        // R9: a draining channel never lands in HALT
        a_r9_stop_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w[n] == 2'(CH_STOP)) |=> (st_w[n] != 2'(CH_HALT)));
        // R4: idle without reload keeps its count
        a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st_w[n]) == 2'(CH_IDLE) && !$past(rld_w[n])) |-> $stable(cnt_w[n]));
        // R10: a status bit rises only after a channel expiry
        a_r10_sts_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_q[n]) |-> $past(exp_w[n]));
    end
endmodule

bind tmr_multi tmr_multi_chk #(.NCH(NCH), .DW(DW)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .ien_q (ien_q),
    .sts_q (sts_q),
    .exp_w (exp_w),
    .rld_w (rld_w),
    .st_w  (st_w),
    .cnt_w (cnt_w)
);

// File: tb/tmr_multi_tb_top.sv
`timescale 1ns/1ps
module tmr_multi_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    tmr_multi dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); bus_sel = 0; d = bus_rdata;
    endtask

    task automatic tick(input logic [3:0] m);
        @(negedge clk); src_tick = m;
        @(negedge clk); src_tick = '0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // drain channel 0: disable, then two source-0 ticks, then clear status
    task automatic stop0();
        wr(8'h10, 32'h0);
        tick(4'b0001);
        tick(4'b0001);
        wr(8'h04, 32'h3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and unmapped offsets
        foreach (v[i]) begin end
        for (int a = 0; a < 'h30; a += 4) rdchk("R1 reset/unmapped", 8'(a), 32'h0);
        rdchk("R1 unmapped 0x30", 8'h30, 32'h0);
        rdchk("R1 misaligned", 8'h16, 32'h0);
        chk("R11 reset irq", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rdchk("R1 ien width", 8'h00, 32'h3);
        wr(8'h00, 32'h0);

        // R2: control field width
        wr(8'h10, 32'hFFFF_FF74);
        rdchk("R2 ctrl readback", 8'h10, 32'h74);
        wr(8'h10, 32'h0);

        // R3: idle reload
        wr(8'h14, 32'd5);
        wr(8'h10, 32'h02);
        rdchk("R3 idle load", 8'h18, 32'd5);
        rdchk("R3 reload self-clears", 8'h10, 32'h0);
        for (int i = 0; i < 3; i++) begin
            tick(4'b0001);
            rdchk("R4 idle holds", 8'h18, 32'd5);
        end

        // R4/R5: periodic sweep over small intervals
        for (int n = 0; n <= 4; n++) begin
            wr(8'h14, 32'(n));
            wr(8'h10, 32'h03);
            wr(8'h04, 32'h1);
            rdchk("R4 start value", 8'h18, 32'(n));
            for (int k = 1; k <= n; k++) begin
                tick(4'b0001);
                rdchk("R4 decrement", 8'h18, 32'(n - k));
                rdchk("R5 no early expiry", 8'h04, 32'h0);
            end
            tick(4'b0001);
            rdchk("R5 expiry sets status", 8'h04, 32'h1);
            rdchk("R5 periodic reload", 8'h18, 32'(n));
            stop0();
        end

        // R9: delayed stop
        wr(8'h14, 32'd20);
        wr(8'h10, 32'h03);
        tick(4'b0001); tick(4'b0001);
        rdchk("R4 run", 8'h18, 32'd18);
        wr(8'h10, 32'h0);
        tick(4'b0001);
        rdchk("R9 first stop tick counts", 8'h18, 32'd17);
        tick(4'b0001);
        rdchk("R9 second stop tick counts", 8'h18, 32'd16);
        tick(4'b0001);
        rdchk("R9 stopped", 8'h18, 32'd16);
        tick(4'b0001);
        rdchk("R9 still stopped", 8'h18, 32'd16);
        wr(8'h10, 32'h01);
        tick(4'b0001);
        rdchk("R9 restart without reload", 8'h18, 32'd15);
        wr(8'h10, 32'h0);
        wr(8'h10, 32'h01);
        for (int k = 1; k <= 4; k++) begin
            tick(4'b0001);
            rdchk("R9 re-enable cancels stop", 8'h18, 32'(15 - k));
        end

        // R3: reload while running waits for a tick
        wr(8'h14, 32'd3);
        rdchk("R3 interval write alone", 8'h18, 32'd11);
        wr(8'h10, 32'h03);
        rdchk("R3 reload pending", 8'h10, 32'h03);
        rdchk("R3 count before tick", 8'h18, 32'd11);
        tick(4'b0001);
        rdchk("R3 reload on tick", 8'h18, 32'd3);
        rdchk("R3 reload cleared", 8'h10, 32'h01);
        stop0();

        // R6: one-shot
        wr(8'h14, 32'd2);
        wr(8'h10, 32'h83);
        tick(4'b0001); tick(4'b0001);
        rdchk("R6 reaches zero", 8'h18, 32'd0);
        rdchk("R6 no expiry yet", 8'h04, 32'h0);
        tick(4'b0001);
        rdchk("R6 expiry status", 8'h04, 32'h1);
        rdchk("R6 holds zero", 8'h18, 32'd0);
        wr(8'h04, 32'h1);
        for (int k = 0; k < 3; k++) tick(4'b0001);
        rdchk("R6 halted count", 8'h18, 32'd0);
        rdchk("R6 no second expiry", 8'h04, 32'h0);
        wr(8'h10, 32'h83);
        rdchk("R6 rearm loads", 8'h18, 32'd2);
        rdchk("R6 rearm clears reload", 8'h10, 32'h81);
        tick(4'b0001);
        rdchk("R6 rearm counts", 8'h18, 32'd1);
        stop0();

        // R12: full range
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h10, 32'h02);
        rdchk("R12 full load", 8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'h01);
        tick(4'b0001);
        rdchk("R12 first step", 8'h18, 32'hFFFF_FFFE);
        tick(4'b0001);
        rdchk("R12 second step", 8'h18, 32'hFFFF_FFFD);
        stop0();

        // R7: prescaler sweep, channel 1 on source 1, one-shot interval 1
        for (int p = 0; p <= 4; p++) begin
            int n;
            n = 0;
            wr(8'h24, 32'd1);
            wr(8'h20, 32'h87 | 32'(p << 4));
            v = 0;
            while (n < 200 && v[1] == 1'b0) begin
                tick(4'b0010);
                n++;
                rd(8'h04, v);
            end
            chk("R7 ticks to expiry", 32'(n), 32'(2 << p));
            wr(8'h20, 32'h0);
            wr(8'h04, 32'h2);
        end

        // R8: source select (source 2 on channel 1)
        wr(8'h24, 32'd4);
        wr(8'h20, 32'h0B);
        for (int k = 0; k < 3; k++) begin tick(4'b0001); tick(4'b0010); end
        rdchk("R8 other sources ignored", 8'h28, 32'd4);
        tick(4'b0100);
        rdchk("R8 selected source counts", 8'h28, 32'd3);
        tick(4'b1000);
        rdchk("R8 source 3 ignored", 8'h28, 32'd3);
        wr(8'h20, 32'h0);
        tick(4'b0100); tick(4'b0100);
        wr(8'h04, 32'h3);

        // R10/R11: status and interrupt
        wr(8'h00, 32'h0);
        wr(8'h14, 32'd0);
        wr(8'h10, 32'h03);
        tick(4'b0001);
        rdchk("R10 sets with enable clear", 8'h04, 32'h1);
        chk("R11 masked", {31'b0, irq}, 32'h0);
        stop0();
        tick(4'b0001);
        wr(8'h10, 32'h03);
        tick(4'b0001);
        wr(8'h10, 32'h0);
        tick(4'b0001); tick(4'b0001);
        rdchk("R10 pending again", 8'h04, 32'h1);
        wr(8'h00, 32'h2);
        chk("R11 other channel enabled", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h1);
        chk("R11 asserted", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h2);
        rdchk("R10 zero bits untouched", 8'h04, 32'h1);
        chk("R11 still asserted", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h1);
        rdchk("R10 cleared", 8'h04, 32'h0);
        chk("R11 deasserted", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule